// File: doc/BRIEF.md
# Prioritized Interrupt Level Recognizer

This block decides when a processor core has to begin an interrupt acknowledge. It takes seven active-low request lines, or optionally a single 3-bit encoded request level, together with the 3-bit priority mask held in the core's status register. Each request passes through a sampling filter, so a line only counts once it has been seen asserted on several consecutive clocks. A filtered request is not latched. It stays pending only while its line stays asserted, and it is acted on only when the core signals an instruction boundary, or signals that higher-priority exception handling has completed, on the `boundary` strobe.

At that strobe the highest pending level is compared against the mask. Levels 1 to 6 are taken only when they are strictly above the mask. Level 7 cannot be masked, but it is recognized on an edge: once when its filtered line becomes asserted, and once more each time the mask falls from 7 to a lower value while the line is still held. On acceptance the block pulses `ack_start`, presents the accepted level on `ack_level` for the acknowledge cycle, and loads that level into the mask, which it owns and exposes on `mask`. The core may also write the mask directly.

Top module: `irq_level_recognizer`

## Requirements
- R1: After a clock edge with `rst_n` low, `ack_start` and `mask_load` are 0, `ack_level` is 0 and `mask` equals RESET_MASK (default 7).
- R2: A request counts as valid only after FILTER_DEPTH consecutive clock edges have sampled it asserted; a shorter assertion never leads to an acknowledge.
- R3: A valid request produces no acknowledge while `boundary` is low. With `boundary` high at a clock edge where a request qualifies, `ack_start` is 1 for the cycle after that edge.
- R4: A request at level 1 to 6 that is equal to or below `mask` is ignored.
- R5: When several qualifying levels are pending together, the highest level is acknowledged.
- R6: Pending state is not latched. A higher request that arrives before the strobe replaces a lower one, and a request released before the strobe is dropped without an acknowledge.
- R7: Level 7 (line `irq_n[6]`, or encoded value 7) is accepted whatever the mask is, but only once for each filtered falling edge of its line. A line held low gives one acknowledge.
- R8: While level 7 stays asserted, each change of `mask` from 7 to a lower value raises one new level-7 acknowledge.
- R9: On acceptance, `ack_start` and `mask_load` are 1 for one cycle, `ack_level` carries the accepted level (never 0), and `mask` equals that level in the same cycle. This load takes precedence over a mask write at the same edge.
- R10: With `mask_wr` high and no acceptance at an edge, `mask` takes `mask_wdata` after that edge.
- R11: With ENCODED_IN=1, `irq_lvl` carries the request level as a binary value (0 means no request, 1 to 7 request that level) and `irq_n` is unused. With ENCODED_IN=0, `irq_n[k]` low requests level k+1 and `irq_lvl` is unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every request is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_n | input | 7 | Active-low request lines; bit k requests level k+1 (line mode) |
| irq_lvl | input | 3 | Binary request level, 0 for none (encoded mode) |
| boundary | input | 1 | Instruction boundary or end of exception handling strobe |
| mask_wr | input | 1 | Core write strobe for the priority mask |
| mask_wdata | input | 3 | Mask value the core writes |
| ack_start | output | 1 | One-cycle pulse that starts an acknowledge cycle |
| ack_level | output | 3 | Level of the acknowledge in progress |
| mask_load | output | 1 | One-cycle pulse when the accepted level is loaded into the mask |
| mask | output | 3 | Current priority mask |

## Verification
The bench builds two instances. The first uses the defaults: line inputs and a two-sample filter, so single-cycle glitches, priority among several lines, and level-7 edges and mask drops can all be driven on separate lines. The second uses ENCODED_IN=1 with FILTER_DEPTH=3. This makes the binary decode reachable, and it also reaches a deeper filter, where the acknowledge latency moves by exactly one cycle and can be sampled on its exact edge.

// File: rtl/irq_pkg.sv
// Shared widths, types and the priority encoder for the interrupt level
// recognizer. Assumes level 0 means "no request" and the top level is the
// non-maskable one.
package irq_pkg;
    localparam int LVL_W   = 3;
    localparam int NUM_LVL = (1 << LVL_W) - 1;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [NUM_LVL:1] lvl_vec_t;

    localparam lvl_t NMI_LVL = lvl_t'(NUM_LVL);

    // Return the highest set level in a vector, 0 when none is set.
    function automatic lvl_t highest(input lvl_vec_t v);
        lvl_t r;
        r = '0;
        for (int i = 1; i <= NUM_LVL; i++) begin
            if (v[i]) r = lvl_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_req_filter.sv
// Per-level sampling filter. A level is reported valid only after DEPTH
// consecutive rising edges have sampled it asserted. Assumes req is
// active-high and DEPTH >= 1.
module irq_req_filter
    import irq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  lvl_vec_t req,
    output lvl_vec_t valid
);
    generate
        for (genvar g = 1; g <= NUM_LVL; g++) begin : g_line
            logic [DEPTH-1:0] hist;

            // Shift the newest sample into the history of this level.
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= (hist << 1) | DEPTH'(req[g]);
            end

            assign valid[g] = &hist;

            // A valid level must have been asserted at the previous edge.
            assert_filter_history_R2: assert property (@(posedge clk)
                disable iff (!rst_n) $rose(valid[g]) |-> $past(req[g]));
        end
    endgenerate
endmodule

// File: rtl/irq_nmi_detect.sv
// Edge recognizer for the non-maskable level. It raises an event when the
// filtered level becomes valid, or when the mask leaves the top value while
// the level is still held. The event stays pending until it is accepted or
// the level is released. Assumes mask is the registered mask of the top.
module irq_nmi_detect
    import irq_pkg::*;
#(
    parameter lvl_t RESET_MASK = NMI_LVL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_valid,
    input  lvl_t mask,
    input  logic accept_nmi,
    output logic nmi_req
);
    logic nmi_q;
    lvl_t mask_prev;
    logic pend;
    logic edge_evt;
    logic drop_evt;

    // Form the two kinds of new events for the current cycle.
    always_comb begin
        edge_evt = nmi_valid && !nmi_q;
        drop_evt = nmi_valid && (mask_prev == NMI_LVL) && (mask != NMI_LVL);
        nmi_req  = pend || edge_evt || drop_evt;
        if (!nmi_valid) nmi_req = 1'b0;
    end

    // Track the previous level and mask, and hold the pending event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q     <= 1'b0;
            mask_prev <= RESET_MASK;
            pend      <= 1'b0;
        end else begin
            nmi_q     <= nmi_valid;
            mask_prev <= mask;
            pend      <= nmi_req && !accept_nmi;
        end
    end

    // One event cannot be accepted on two consecutive edges.
    assert_single_nmi_R7: assert property (@(posedge clk)
        disable iff (!rst_n) accept_nmi |=> !accept_nmi);
endmodule

// File: rtl/irq_arbiter.sv
// Picks the highest pending level, qualifies it against the mask and the
// boundary strobe, and registers the acknowledge outputs. The top level
// bypasses the mask. Assumes pend has bit NUM_LVL as the non-maskable event.
module irq_arbiter
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lvl_vec_t pend,
    input  lvl_t     mask,
    input  logic     boundary,
    output logic     accept,
    output lvl_t     top_lvl,
    output logic     ack_start,
    output lvl_t     ack_level,
    output logic     mask_load
);
    // Choose the winning level and decide whether it is taken now.
    always_comb begin
        top_lvl = highest(pend);
        accept  = boundary && (top_lvl != '0) &&
                  ((top_lvl == NMI_LVL) || (top_lvl > mask));
    end

    // Register the acknowledge pulse and the level it carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_start <= 1'b0;
            mask_load <= 1'b0;
            ack_level <= '0;
        end else begin
            ack_start <= accept;
            mask_load <= accept;
            if (accept) ack_level <= top_lvl;
        end
    end

    assert_needs_boundary_R3: assert property (@(posedge clk)
        disable iff (!rst_n) ack_start |-> $past(boundary));

    assert_above_mask_R4: assert property (@(posedge clk)
        disable iff (!rst_n) (ack_start && ack_level != NMI_LVL) |->
            (ack_level > $past(mask)));

    assert_level_nonzero_R9: assert property (@(posedge clk)
        disable iff (!rst_n) ack_start |-> (ack_level != '0));
endmodule

// File: rtl/irq_level_recognizer.sv
// Top of the interrupt level recognizer. A front end chosen by ENCODED_IN
// turns line or binary requests into one bit per level. The filter, the
// non-maskable edge detector and the arbiter follow, and the priority mask
// register lives here. Assumes boundary is a single-cycle strobe from the core.
module irq_level_recognizer
    import irq_pkg::*;
#(
    parameter int   FILTER_DEPTH = 2,
    parameter bit   ENCODED_IN   = 1'b0,
    parameter lvl_t RESET_MASK   = NMI_LVL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_LVL-1:0] irq_n,
    input  logic [LVL_W-1:0] irq_lvl,
    input  logic             boundary,
    input  logic             mask_wr,
    input  logic [LVL_W-1:0] mask_wdata,
    output logic             ack_start,
    output logic [LVL_W-1:0] ack_level,
    output logic             mask_load,
    output logic [LVL_W-1:0] mask
);
    lvl_vec_t raw_req;
    lvl_vec_t valid;
    lvl_vec_t pend;
    logic     nmi_req;
    logic     accept;
    lvl_t     top_lvl;

    generate
        if (ENCODED_IN) begin : g_enc
            logic [NUM_LVL-1:0] unused_lines;
            assign unused_lines = irq_n;
            // Decode the binary level into one request bit.
            always_comb begin
                raw_req = '0;
                for (int i = 1; i <= NUM_LVL; i++) begin
                    if (irq_lvl == lvl_t'(i)) raw_req[i] = 1'b1;
                end
            end
        end else begin : g_lines
            logic [LVL_W-1:0] unused_lvl;
            assign unused_lvl = irq_lvl;
            // Invert the active-low lines into level requests.
            always_comb begin
                for (int i = 1; i <= NUM_LVL; i++) raw_req[i] = !irq_n[i-1];
            end
        end
    endgenerate

    irq_req_filter #(.DEPTH(FILTER_DEPTH)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (raw_req),
        .valid (valid)
    );

    irq_nmi_detect #(.RESET_MASK(RESET_MASK)) u_nmi (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_valid  (valid[NUM_LVL]),
        .mask       (mask),
        .accept_nmi (accept && (top_lvl == NMI_LVL)),
        .nmi_req    (nmi_req)
    );

    // Maskable levels follow their filter, the top level its edge event.
    always_comb begin
        pend          = valid;
        pend[NUM_LVL] = nmi_req;
    end

    irq_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .mask      (mask),
        .boundary  (boundary),
        .accept    (accept),
        .top_lvl   (top_lvl),
        .ack_start (ack_start),
        .ack_level (ack_level),
        .mask_load (mask_load)
    );

    // Mask register: an accepted level wins over a core write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= RESET_MASK;
        else if (accept)  mask <= top_lvl;
        else if (mask_wr) mask <= mask_wdata;
    end

    assert_mask_follows_ack_R9: assert property (@(posedge clk)
        disable iff (!rst_n) ack_start |-> (mask == ack_level));

    assert_mask_write_R10: assert property (@(posedge clk)
        disable iff (!rst_n) ($past(mask_wr) && !ack_start) |->
            (mask == $past(mask_wdata)));
endmodule

// File: tb/irq_level_recognizer_bench.sv
module irq_level_recognizer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] irq_n = 7'h7f;
    logic       boundary = 1'b0;
    logic       mask_wr = 1'b0;
    logic [2:0] mask_wdata = 3'd0;
    logic       ack_start, mask_load;
    logic [2:0] ack_level, mask;

    logic [2:0] e_lvl = 3'd0;
    logic       e_wr = 1'b0;
    logic       e_ack, e_load;
    logic [2:0] e_ack_level, e_mask;

    int checks = 0;
    int fails = 0;
    int acks = 0;
    logic [2:0] last_lvl = 3'd0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_level_recognizer u_irq_level_recognizer (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .irq_lvl(3'd0),
        .boundary(boundary), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .ack_start(ack_start), .ack_level(ack_level),
        .mask_load(mask_load), .mask(mask));

    irq_level_recognizer #(.FILTER_DEPTH(3), .ENCODED_IN(1'b1)) u_irq_level_recognizer_enc (
        .clk(clk), .rst_n(rst_n), .irq_n(7'h7f), .irq_lvl(e_lvl),
        .boundary(boundary), .mask_wr(e_wr), .mask_wdata(3'd0),
        .ack_start(e_ack), .ack_level(e_ack_level),
        .mask_load(e_load), .mask(e_mask));

    // Count acknowledges of the line-mode instance, sampled after each edge.
    always begin
        @(posedge clk);
        #1;
        if (ack_start) begin
            acks++;
            last_lvl = ack_level;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        irq_n = 7'h7f; e_lvl = 3'd0; boundary = 1'b0; mask_wr = 1'b0; e_wr = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        cyc(2); rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic write_mask(input logic [2:0] v);
        mask_wdata = v; mask_wr = 1'b1;
        cyc(1);
        mask_wr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(!ack_start && !mask_load, "R1 pulses low", int'(ack_start), 0);
        check(ack_level == 3'd0, "R1 ack_level", int'(ack_level), 0);
        check(mask == 3'd7, "R1 mask", int'(mask), 7);
        check(e_mask == 3'd7 && !e_ack, "R1 enc mask", int'(e_mask), 7);
    endtask

    task automatic t_mask_write();
        do_reset();
        write_mask(3'd2);
        check(mask == 3'd2, "R10 mask write", int'(mask), 2);
    endtask

    task automatic t_filter();
        int a0;
        do_reset();
        write_mask(3'd0);
        boundary = 1'b1;
        a0 = acks;
        irq_n[2] = 1'b0; cyc(1); irq_n[2] = 1'b1;
        cyc(6);
        check(acks == a0, "R2 one-sample glitch ignored", acks - a0, 0);
        irq_n[2] = 1'b0;
        cyc(2);
        check(!ack_start, "R2 not yet after two edges", int'(ack_start), 0);
        cyc(1);
        check(ack_start && ack_level == 3'd3, "R2 level 3 after filter", int'(ack_level), 3);
        check(mask_load && mask == 3'd3, "R9 mask loaded", int'(mask), 3);
        cyc(1);
        check(!ack_start && !mask_load, "R9 single-cycle pulse", int'(ack_start), 0);
        boundary = 1'b0;
    endtask

    task automatic t_boundary();
        int a0;
        do_reset();
        write_mask(3'd0);
        a0 = acks;
        irq_n[3] = 1'b0;
        cyc(6);
        check(acks == a0, "R3 no ack without boundary", acks - a0, 0);
        boundary = 1'b1; cyc(1); boundary = 1'b0;
        check(ack_start && ack_level == 3'd4, "R3 ack after strobe", int'(ack_level), 4);
        check(mask == 3'd4, "R9 mask is 4", int'(mask), 4);
    endtask

    task automatic t_mask_ignore();
        int a0;
        do_reset();
        write_mask(3'd5);
        boundary = 1'b1;
        a0 = acks;
        irq_n[4] = 1'b0; irq_n[2] = 1'b0;
        cyc(8);
        check(acks == a0, "R4 levels 5 and 3 under mask 5", acks - a0, 0);
        irq_n[5] = 1'b0;
        cyc(4);
        check(acks == a0 + 1 && last_lvl == 3'd6, "R4 level 6 above mask", int'(last_lvl), 6);
        boundary = 1'b0;
    endtask

    task automatic t_priority();
        int a0;
        do_reset();
        write_mask(3'd0);
        boundary = 1'b1;
        a0 = acks;
        irq_n[1] = 1'b0; irq_n[4] = 1'b0; irq_n[2] = 1'b0;
        cyc(8);
        check(acks == a0 + 1, "R5 one ack only", acks - a0, 1);
        check(last_lvl == 3'd5 && mask == 3'd5, "R5 highest level 5", int'(last_lvl), 5);
        boundary = 1'b0;
    endtask

    task automatic t_replace();
        int a0;
        do_reset();
        write_mask(3'd0);
        a0 = acks;
        irq_n[1] = 1'b0; cyc(4);
        irq_n[5] = 1'b0; irq_n[1] = 1'b1; cyc(4);
        boundary = 1'b1; cyc(1); boundary = 1'b0;
        check(ack_start && ack_level == 3'd6, "R6 higher replaces lower", int'(ack_level), 6);
        cyc(3);
        check(acks == a0 + 1, "R6 lower not served", acks - a0, 1);
        do_reset();
        write_mask(3'd0);
        a0 = acks;
        irq_n[2] = 1'b0; cyc(4); irq_n[2] = 1'b1; cyc(2);
        boundary = 1'b1; cyc(4); boundary = 1'b0;
        check(acks == a0 && mask == 3'd0, "R6 released request dropped", acks - a0, 0);
    endtask

    task automatic t_nmi_edge();
        int a0;
        do_reset();
        boundary = 1'b1;
        a0 = acks;
        irq_n[6] = 1'b0;
        cyc(3);
        check(ack_start && ack_level == 3'd7, "R7 level 7 under mask 7", int'(ack_level), 7);
        cyc(12);
        check(acks == a0 + 1, "R7 held line served once", acks - a0, 1);
        irq_n[6] = 1'b1; cyc(4);
        irq_n[6] = 1'b0; cyc(5);
        check(acks == a0 + 2 && last_lvl == 3'd7, "R7 new edge served", acks - a0, 2);
        boundary = 1'b0;
    endtask

    task automatic t_nmi_remask();
        int a0;
        do_reset();
        boundary = 1'b1;
        irq_n[6] = 1'b0;
        cyc(6);
        a0 = acks;
        write_mask(3'd3);
        cyc(1);
        check(ack_start && ack_level == 3'd7, "R8 mask drop retriggers", int'(ack_level), 7);
        cyc(6);
        check(acks == a0 + 1 && mask == 3'd7, "R8 single retrigger", acks - a0, 1);
        boundary = 1'b0;
    endtask

    task automatic t_precedence();
        do_reset();
        write_mask(3'd0);
        irq_n[3] = 1'b0; cyc(4);
        boundary = 1'b1; mask_wdata = 3'd1; mask_wr = 1'b1;
        cyc(1);
        boundary = 1'b0; mask_wr = 1'b0;
        check(ack_start && mask == 3'd4, "R9 accept beats mask write", int'(mask), 4);
    endtask

    task automatic t_encoded();
        do_reset();
        e_wr = 1'b1; cyc(1); e_wr = 1'b0;
        check(e_mask == 3'd0, "R10 enc mask write", int'(e_mask), 0);
        boundary = 1'b1;
        e_lvl = 3'd5;
        cyc(3);
        check(!e_ack, "R11 depth 3 not yet", int'(e_ack), 0);
        cyc(1);
        check(e_ack && e_ack_level == 3'd5, "R11 encoded level 5", int'(e_ack_level), 5);
        e_lvl = 3'd7;
        cyc(4);
        check(e_ack && e_ack_level == 3'd7, "R11 encoded level 7", int'(e_ack_level), 7);
        boundary = 1'b0; e_lvl = 3'd0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_mask_write();
        t_filter();
        t_boundary();
        t_mask_ignore();
        t_priority();
        t_replace();
        t_nmi_edge();
        t_nmi_remask();
        t_precedence();
        t_encoded();
        summary();
    end
endmodule